// File: doc/BRIEF.md
# Interrupt Response Sequencer

This unit is the interrupt-handling control of a small 8-bit processor, built as a standalone block. It keeps the two interrupt-enable flip-flops (a live enable and a saved copy), the maskable response mode and the vector-page register. The instruction decoder passes it already-decoded flag and mode commands. The core pulses `boundary` between instructions. At that pulse the unit decides whether a non-maskable or a maskable request is taken.

Once a request is accepted, the unit runs the response on its own. A non-maskable request and the fixed-address mode finish at once. The restart mode runs one acknowledge bus cycle and decodes the byte the device places on the bus. The table mode runs one acknowledge cycle and then two memory reads to fetch a 16-bit handler address. Every response ends with a one-cycle strobe. The strobe carries the new program-counter target and a request to push the old program counter.

Top module: `irq_seq`

## Requirements
- R1: After reset both enable flags are 0, the mode is 0, the vector page is 0x00, `busy`, `done`, `push_pc` and `mem_rd` are 0, and both acknowledge strobes are high.
- R2: With `cmd_valid` high, command code 1 (enable) sets both flags and code 2 (disable) clears both.
- R3: A request is considered only on a cycle with `boundary` high while `busy` is low. A maskable request is taken only if the live flag is 1. A boundary raised during a response is ignored.
- R4: A non-maskable request is taken whatever the flags hold, and it wins over a maskable request at the same boundary. It copies the live flag into the saved flag and clears the live flag. It drives no acknowledge cycle and no memory read. `done` rises on the cycle after acceptance with target 0x0066.
- R5: Accepting a maskable request clears both flags.
- R6: Command code 6 (return from non-maskable) copies the saved flag into the live flag.
- R7: Command codes 3, 4 and 5 select modes 0, 1 and 2. Code 7 loads the vector page from `cmd_data`. Code 0 does nothing.
- R8: In mode 1 the target is 0x0038. There is no acknowledge cycle and no memory read, and `done` rises on the cycle after acceptance.
- R9: In mode 0 one acknowledge cycle is run, with `ack_iorq_n` and `ack_m1_n` both low, and `bus_data` is sampled. A byte with bits 7:6 = 11 and bits 2:0 = 111 gives target bits 5:3 × 8 with `bad_op` 0. Any other byte gives 0x0038 with `bad_op` 1.
- R10: In mode 2 one acknowledge cycle is followed by two single-cycle reads. The first read is at {page, bus byte} and the second at that address + 1, wrapping at 16 bits. The target is {second byte, first byte}.
- R11: `done` and `push_pc` rise together for exactly one cycle per accepted request, with `target` and `bad_op` valid in that cycle.
- R12: A command presented in the same cycle as an accepted request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary | input | 1 | Instruction boundary strobe |
| nmi_req | input | 1 | Non-maskable request |
| int_req | input | 1 | Maskable request |
| cmd_valid | input | 1 | Command strobe |
| cmd | input | 3 | Command code |
| cmd_data | input | 8 | Operand for page load |
| bus_data | input | 8 | Byte on the data bus during acknowledge |
| ack_iorq_n | output | 1 | Acknowledge I/O-request, low active |
| ack_m1_n | output | 1 | Acknowledge machine-cycle-one, low active |
| mem_rd | output | 1 | Vector table read strobe |
| mem_addr | output | 16 | Vector table read address |
| mem_data | input | 8 | Read data, valid in the cycle of `mem_rd` |
| done | output | 1 | Response complete |
| push_pc | output | 1 | Push the current program counter |
| target | output | 16 | New program counter |
| bad_op | output | 1 | Mode 0 byte was not a restart opcode |
| busy | output | 1 | Response in progress |
| iff1 | output | 1 | Live enable flag |
| iff2 | output | 1 | Saved enable flag |
| mode | output | 2 | Maskable response mode |
| ireg | output | 8 | Vector page register |

## Verification
Two functions can fall in the same clock edge. The first is a flag or mode command arriving at the boundary where a request is accepted. The second is a non-maskable and a maskable request raised together. The bench provokes the first by presenting an enable command with an accepted mode 0 request, and a mode-select command with an accepted mode 2 request. It then reads the flag and mode outputs to confirm the commands were dropped. For the second, it raises both requests together and expects exactly one completion at 0x0066. It also raises a fresh boundary in the middle of a table fetch and expects no second completion.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
    typedef enum logic [2:0] {
        CMD_NONE = 3'd0,
        CMD_EI   = 3'd1,
        CMD_DI   = 3'd2,
        CMD_IM0  = 3'd3,
        CMD_IM1  = 3'd4,
        CMD_IM2  = 3'd5,
        CMD_RETN = 3'd6,
        CMD_LDI  = 3'd7
    } irq_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACK,
        ST_VLO,
        ST_VHI,
        ST_DONE
    } seq_state_e;

    localparam logic [1:0] MODE_RST = 2'd0;
    localparam logic [1:0] MODE_FIX = 2'd1;
    localparam logic [1:0] MODE_VEC = 2'd2;
endpackage

// File: rtl/irq_flags.sv
module irq_flags
    import irq_seq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd,
    input  logic [DW-1:0] cmd_data,
    input  logic          accept,
    input  logic          accept_nmi,
    output logic          iff1,
    output logic          iff2,
    output logic [1:0]    mode,
    output logic [DW-1:0] ireg
);
    typedef struct packed {
        logic          iff1;
        logic          iff2;
        logic [1:0]    mode;
        logic [DW-1:0] ireg;
    } flags_t;

    flags_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (accept) begin
            f_d.iff1 = 1'b0;
            f_d.iff2 = accept_nmi ? f_q.iff1 : 1'b0;
        end else if (cmd_valid) begin
            case (irq_cmd_e'(cmd))
                CMD_EI:   begin f_d.iff1 = 1'b1; f_d.iff2 = 1'b1; end
                CMD_DI:   begin f_d.iff1 = 1'b0; f_d.iff2 = 1'b0; end
                CMD_IM0:  f_d.mode = MODE_RST;
                CMD_IM1:  f_d.mode = MODE_FIX;
                CMD_IM2:  f_d.mode = MODE_VEC;
                CMD_RETN: f_d.iff1 = f_q.iff2;
                CMD_LDI:  f_d.ireg = cmd_data;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign iff1 = f_q.iff1;
    assign iff2 = f_q.iff2;
    assign mode = f_q.mode;
    assign ireg = f_q.ireg;

    // R6
    retn_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd == CMD_RETN && !accept) |=> (iff1 == $past(iff2)));

    // R4
    nmi_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && accept_nmi) |=> (!iff1 && iff2 == $past(iff1)));

    // R5
    mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !accept_nmi) |=> (!iff1 && !iff2));

    // R12
    cmd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_valid) |=> ($stable(mode) && $stable(ireg)));
endmodule

// File: rtl/irq_rst_decode.sv
module irq_rst_decode #(
    parameter int DW = 8,
    parameter int AW = 16,
    parameter int unsigned FALLBACK = 'h38
) (
    input  logic [DW-1:0] op,
    output logic          hit,
    output logic [AW-1:0] addr
);
    assign hit  = (op[7:6] == 2'b11) && (op[2:0] == 3'b111);
    assign addr = hit ? AW'({op[5:3], 3'b000}) : AW'(FALLBACK);
endmodule

// File: rtl/irq_fsm.sv
module irq_fsm
    import irq_seq_pkg::*;
#(
    parameter int DW = 8,
    parameter int unsigned NMI_ADDR = 'h66,
    parameter int unsigned FIX_ADDR = 'h38,
    localparam int AW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          boundary,
    input  logic          nmi_req,
    input  logic          int_req,
    input  logic          iff1,
    input  logic [1:0]    mode,
    input  logic [DW-1:0] ireg,
    input  logic [DW-1:0] bus_data,
    input  logic [DW-1:0] mem_data,
    output logic          accept,
    output logic          accept_nmi,
    output logic          ack,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    output logic          done,
    output logic [AW-1:0] target,
    output logic          bad_op,
    output logic          busy
);
    typedef struct packed {
        seq_state_e    st;
        logic [1:0]    mode;
        logic [AW-1:0] tgt;
        logic [AW-1:0] ptr;
        logic          bad;
    } seq_t;

    seq_t s_d, s_q;

    logic          rst_hit;
    logic [AW-1:0] rst_addr;

    irq_rst_decode #(
        .DW(DW),
        .AW(AW),
        .FALLBACK(FIX_ADDR)
    ) u_dec (
        .op  (bus_data),
        .hit (rst_hit),
        .addr(rst_addr)
    );

    always_comb begin
        s_d        = s_q;
        accept     = 1'b0;
        accept_nmi = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (boundary && nmi_req) begin
                    accept     = 1'b1;
                    accept_nmi = 1'b1;
                    s_d.tgt    = AW'(NMI_ADDR);
                    s_d.bad    = 1'b0;
                    s_d.st     = ST_DONE;
                end else if (boundary && int_req && iff1) begin
                    accept   = 1'b1;
                    s_d.mode = mode;
                    s_d.bad  = 1'b0;
                    if (mode == MODE_FIX) begin
                        s_d.tgt = AW'(FIX_ADDR);
                        s_d.st  = ST_DONE;
                    end else begin
                        s_d.st = ST_ACK;
                    end
                end
            end
            ST_ACK: begin
                if (s_q.mode == MODE_VEC) begin
                    s_d.ptr = {ireg, bus_data};
                    s_d.st  = ST_VLO;
                end else begin
                    s_d.tgt = rst_addr;
                    s_d.bad = !rst_hit;
                    s_d.st  = ST_DONE;
                end
            end
            ST_VLO: begin
                s_d.tgt[DW-1:0] = mem_data;
                s_d.ptr         = s_q.ptr + AW'(1);
                s_d.st          = ST_VHI;
            end
            ST_VHI: begin
                s_d.tgt[AW-1:DW] = mem_data;
                s_d.st           = ST_DONE;
            end
            ST_DONE: s_d.st = ST_IDLE;
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, mode: MODE_RST, tgt: '0, ptr: '0, bad: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign ack      = (s_q.st == ST_ACK);
    assign mem_rd   = (s_q.st == ST_VLO) || (s_q.st == ST_VHI);
    assign mem_addr = s_q.ptr;
    assign done     = (s_q.st == ST_DONE);
    assign target   = s_q.tgt;
    assign bad_op   = s_q.bad;
    assign busy     = (s_q.st != ST_IDLE);

    // R10
    rd_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd) |=> mem_rd);

    // R10
    rd_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd)) |=> !mem_rd);

    // R10
    rd_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + AW'(1)));

    // R11
    done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    fixed_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !accept_nmi && mode == MODE_FIX) |=> (done && target == AW'(FIX_ADDR)));

    // R4
    nmi_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && accept_nmi) |=> (done && !bad_op && target == AW'(NMI_ADDR)));

    // R3
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !accept);
endmodule

// File: rtl/irq_seq.sv
module irq_seq #(
    parameter int DW = 8,
    parameter int unsigned NMI_ADDR = 'h66,
    parameter int unsigned FIX_ADDR = 'h38
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            boundary,
    input  logic            nmi_req,
    input  logic            int_req,
    input  logic            cmd_valid,
    input  logic [2:0]      cmd,
    input  logic [DW-1:0]   cmd_data,
    input  logic [DW-1:0]   bus_data,
    output logic            ack_iorq_n,
    output logic            ack_m1_n,
    output logic            mem_rd,
    output logic [2*DW-1:0] mem_addr,
    input  logic [DW-1:0]   mem_data,
    output logic            done,
    output logic            push_pc,
    output logic [2*DW-1:0] target,
    output logic            bad_op,
    output logic            busy,
    output logic            iff1,
    output logic            iff2,
    output logic [1:0]      mode,
    output logic [DW-1:0]   ireg
);
    logic accept;
    logic accept_nmi;
    logic ack;

    irq_flags #(.DW(DW)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .cmd_data  (cmd_data),
        .accept    (accept),
        .accept_nmi(accept_nmi),
        .iff1      (iff1),
        .iff2      (iff2),
        .mode      (mode),
        .ireg      (ireg)
    );

    irq_fsm #(
        .DW      (DW),
        .NMI_ADDR(NMI_ADDR),
        .FIX_ADDR(FIX_ADDR)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .boundary  (boundary),
        .nmi_req   (nmi_req),
        .int_req   (int_req),
        .iff1      (iff1),
        .mode      (mode),
        .ireg      (ireg),
        .bus_data  (bus_data),
        .mem_data  (mem_data),
        .accept    (accept),
        .accept_nmi(accept_nmi),
        .ack       (ack),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .done      (done),
        .target    (target),
        .bad_op    (bad_op),
        .busy      (busy)
    );

    assign ack_iorq_n = !ack;
    assign ack_m1_n   = !ack;
    assign push_pc    = done;

    // R9
    ack_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_m1_n |-> (!ack_iorq_n && busy && !mem_rd));
endmodule

// File: tb/irq_seq_tb.sv
module irq_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boundary = 1'b0;
    logic        nmi_req = 1'b0;
    logic        int_req = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd = 3'd0;
    logic [7:0]  cmd_data = 8'd0;
    logic [7:0]  bus_data = 8'd0;
    logic        ack_iorq_n, ack_m1_n, mem_rd, done, push_pc, bad_op, busy;
    logic        iff1, iff2;
    logic [1:0]  mode;
    logic [7:0]  ireg, mem_data;
    logic [15:0] mem_addr, target;

    always #2 clk = ~clk;

    function automatic logic [7:0] memf(input logic [15:0] a);
        return a[15:8] ^ {a[3:0], a[7:4]} ^ 8'hA5;
    endfunction

    assign mem_data = memf(mem_addr);

    irq_seq u_dut (
        .clk(clk), .rst_n(rst_n), .boundary(boundary), .nmi_req(nmi_req),
        .int_req(int_req), .cmd_valid(cmd_valid), .cmd(cmd), .cmd_data(cmd_data),
        .bus_data(bus_data), .ack_iorq_n(ack_iorq_n), .ack_m1_n(ack_m1_n),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_data(mem_data), .done(done),
        .push_pc(push_pc), .target(target), .bad_op(bad_op), .busy(busy),
        .iff1(iff1), .iff2(iff2), .mode(mode), .ireg(ireg)
    );

    typedef struct {
        logic [15:0] tgt;
        logic        bad;
        int          nack;
        int          nrd;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    int   n_done = 0;
    int   nack = 0;
    int   nrd = 0;
    logic prev_done = 1'b0;
    bit   finished = 1'b0;

    function automatic exp_t mk(string tag, logic [15:0] t, logic b, int na, int nr);
        exp_t e;
        e.tgt = t; e.bad = b; e.nack = na; e.nrd = nr; e.tag = tag;
        return e;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on each completion strobe
    always @(negedge clk) begin
        if (rst_n) begin
            if (!ack_iorq_n && !ack_m1_n) nack++;
            if (mem_rd) nrd++;
            if (done) begin
                exp_t e;
                n_done++;
                chk("R11 push_pc with done", 16'(push_pc), 16'd1);
                if (prev_done) chk("R11 done single cycle", 16'd1, 16'd0);
                if (q.size() == 0) begin
                    chk("R11 unexpected done", 16'd1, 16'd0);
                end else begin
                    e = q.pop_front();
                    chk({e.tag, " target"}, target, e.tgt);
                    chk({e.tag, " bad_op"}, 16'(bad_op), 16'(e.bad));
                    chk({e.tag, " ack cycles"}, 16'(nack), 16'(e.nack));
                    chk({e.tag, " reads"}, 16'(nrd), 16'(e.nrd));
                end
                nack = 0;
                nrd = 0;
            end
            prev_done = done;
        end
    end

    task automatic do_cmd(input logic [2:0] c, input logic [7:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd = c; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0; cmd = 3'd0;
    endtask

    // Driver: pushes the expected item, then pulses the boundary
    task automatic raise(input logic n, input logic i, input logic [2:0] c,
                         input logic [7:0] d, input logic want, input exp_t e);
        @(negedge clk);
        if (want) q.push_back(e);
        boundary = 1'b1; nmi_req = n; int_req = i;
        cmd_valid = (c != 3'd0); cmd = c; cmd_data = d;
        @(negedge clk);
        boundary = 1'b0; nmi_req = 1'b0; int_req = 1'b0;
        cmd_valid = 1'b0; cmd = 3'd0;
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int base;
        exp_t none;
        none = mk("none", 16'h0, 1'b0, 0, 0);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 iff1", 16'(iff1), 16'd0);
        chk("R1 iff2", 16'(iff2), 16'd0);
        chk("R1 mode", 16'(mode), 16'd0);
        chk("R1 ireg", 16'(ireg), 16'd0);
        chk("R1 busy", 16'(busy), 16'd0);
        chk("R1 done", 16'(done), 16'd0);
        chk("R1 mem_rd", 16'(mem_rd), 16'd0);
        chk("R1 ack strobes", 16'({ack_iorq_n, ack_m1_n}), 16'd3);

        // R3 masked request ignored while live flag is clear
        raise(1'b0, 1'b1, 3'd0, 8'd0, 1'b0, none);
        chk("R3 masked ignored busy", 16'(busy), 16'd0);
        chk("R3 masked ignored done count", 16'(n_done), 16'd0);

        // R2 enable / disable
        do_cmd(3'd1, 8'd0);
        chk("R2 enable iff1", 16'(iff1), 16'd1);
        chk("R2 enable iff2", 16'(iff2), 16'd1);
        do_cmd(3'd2, 8'd0);
        chk("R2 disable iff1", 16'(iff1), 16'd0);
        chk("R2 disable iff2", 16'(iff2), 16'd0);

        // R9 restart opcodes in mode 0
        do_cmd(3'd1, 8'd0);
        bus_data = 8'hD7;
        raise(1'b0, 1'b1, 3'd0, 8'd0, 1'b1, mk("R9 restart D7", 16'h0010, 1'b0, 1, 0));
        chk("R5 iff1 cleared", 16'(iff1), 16'd0);
        chk("R5 iff2 cleared", 16'(iff2), 16'd0);
        do_cmd(3'd1, 8'd0);
        bus_data = 8'hFF;
        raise(1'b0, 1'b1, 3'd0, 8'd0, 1'b1, mk("R9 restart FF", 16'h0038, 1'b0, 1, 0));
        do_cmd(3'd1, 8'd0);
        bus_data = 8'h3E;
        raise(1'b0, 1'b1, 3'd0, 8'd0, 1'b1, mk("R9 non-restart fallback", 16'h0038, 1'b1, 1, 0));

        // R12 enable command at an accepted boundary is dropped
        do_cmd(3'd1, 8'd0);
        bus_data = 8'hCF;
        raise(1'b0, 1'b1, 3'd1, 8'd0, 1'b1, mk("R9 restart CF", 16'h0008, 1'b0, 1, 0));
        chk("R12 enable dropped iff1", 16'(iff1), 16'd0);

        // R7 / R8 fixed mode
        do_cmd(3'd4, 8'd0);
        chk("R7 mode 1", 16'(mode), 16'd1);
        do_cmd(3'd1, 8'd0);
        bus_data = 8'hC7;
        raise(1'b0, 1'b1, 3'd0, 8'd0, 1'b1, mk("R8 fixed mode", 16'h0038, 1'b0, 0, 0));

        // R7 / R10 table mode
        do_cmd(3'd7, 8'h12);
        chk("R7 page load", 16'(ireg), 16'h0012);
        do_cmd(3'd5, 8'd0);
        chk("R7 mode 2", 16'(mode), 16'd2);
        do_cmd(3'd1, 8'd0);
        bus_data = 8'h34;
        raise(1'b0, 1'b1, 3'd0, 8'd0, 1'b1,
              mk("R10 table 1234", {memf(16'h1235), memf(16'h1234)}, 1'b0, 1, 2));
        do_cmd(3'd7, 8'hFF);
        do_cmd(3'd1, 8'd0);
        bus_data = 8'hFF;
        raise(1'b0, 1'b1, 3'd0, 8'd0, 1'b1,
              mk("R10 table wrap", {memf(16'h0000), memf(16'hFFFF)}, 1'b0, 1, 2));

        // R12 mode command at an accepted boundary is dropped
        do_cmd(3'd1, 8'd0);
        bus_data = 8'h34;
        raise(1'b0, 1'b1, 3'd4, 8'd0, 1'b1,
              mk("R10 table FF34", {memf(16'hFF35), memf(16'hFF34)}, 1'b0, 1, 2));
        chk("R12 mode unchanged", 16'(mode), 16'd2);

        // R3 boundary during a response is ignored
        do_cmd(3'd1, 8'd0);
        base = n_done;
        @(negedge clk);
        q.push_back(mk("R3 busy table", {memf(16'hFF35), memf(16'hFF34)}, 1'b0, 1, 2));
        boundary = 1'b1; int_req = 1'b1;
        @(negedge clk);
        boundary = 1'b1; nmi_req = 1'b1; int_req = 1'b0;
        @(negedge clk);
        boundary = 1'b0; nmi_req = 1'b0;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R3 single completion", 16'(n_done - base), 16'd1);

        // R4 non-maskable wins and saves the live flag
        do_cmd(3'd1, 8'd0);
        raise(1'b1, 1'b1, 3'd0, 8'd0, 1'b1, mk("R4 nmi over maskable", 16'h0066, 1'b0, 0, 0));
        chk("R4 live flag cleared", 16'(iff1), 16'd0);
        chk("R4 saved flag", 16'(iff2), 16'd1);
        do_cmd(3'd6, 8'd0);
        chk("R6 restore set", 16'(iff1), 16'd1);
        do_cmd(3'd2, 8'd0);
        raise(1'b1, 1'b0, 3'd0, 8'd0, 1'b1, mk("R4 nmi while disabled", 16'h0066, 1'b0, 0, 0));
        chk("R4 saved flag clear", 16'(iff2), 16'd0);
        do_cmd(3'd6, 8'd0);
        chk("R6 restore clear", 16'(iff1), 16'd0);

        repeat (5) @(negedge clk);
        chk("R11 scoreboard drained", 16'(q.size()), 16'd0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule